// File: doc/BRIEF.md
# Leading/Trailing Zero Counter

This block counts the zero bits at one end of a data word. With the direction input low it counts from the most significant bit down to the first one bit. With the direction input high it counts from the least significant bit up to the first one bit. A word-mode input restricts the count to the low half of the operand and ignores the upper half completely. The count is returned zero-extended to the full data width, so an integer execution pipeline can write it back like any other result.

The count is built as a tree in which each node covers four children. At every level the same 4-bit priority encoder picks the first non-empty child, and a 4:1 multiplexer forwards that child's partial count. Trailing counts reuse the same tree by feeding it the bit-reversed operand. The all-zero test runs beside the tree and only steers the final result multiplexer. A parameter adds an output register, so the count appears one clock after the operand is presented.

Top module: `zcount_unit`

## Requirements
- R1: With `countTrailing` = 0 and `wordMode` = 0, a non-zero operand gives the number of zero bits above its highest set bit (0 to 63).
- R2: With `countTrailing` = 1 and `wordMode` = 0, a non-zero operand gives the number of zero bits below its lowest set bit (0 to 63).
- R3: With `countTrailing` = 0 and `wordMode` = 1, the result is the leading-zero count of bits 31:0 only (0 to 32), whatever bits 63:32 hold.
- R4: With `countTrailing` = 1 and `wordMode` = 1, the result is the trailing-zero count of bits 31:0 only (0 to 32), whatever bits 63:32 hold.
- R5: An all-zero operand gives 64 when `wordMode` = 0. When `wordMode` = 1 and bits 31:0 are zero, the result is 32. Both hold in either direction.
- R6: Bits 63:7 of `result` are always zero. The count sits in bits 6:0.
- R7: With `REG_OUT` = 1, the result for the inputs sampled at a rising clock edge appears after that edge and holds until the next edge. While `rst_n` is low, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| operand | input | 64 | Data word to be counted |
| countTrailing | input | 1 | 0 = count from the top, 1 = count from the bottom |
| wordMode | input | 1 | 1 = count only bits 31:0 |
| result | output | 64 | Zero count, zero-extended |

## Verification
The bench builds the block with its defaults: a 64-bit width, which gives a three-level tree of 4-wide nodes, and the output register on. With this width, single-bit walks reach every multiplexer leg at every level in both directions. Word-mode runs with noisy upper halves show that the unused half cannot leak into the count. With the register enabled, the bench also confirms that the result holds between clock edges and is cleared during reset.

// File: rtl/zc_pkg.sv
package zc_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic revEn;   // feed the tree the bit-reversed operand
    logic halfEn;  // only the low half of the operand counts
  } zcStrobe_t;

  // index (from the top) of the first set bit among four; 3 when none
  function automatic logic [1:0] pe4(input logic [3:0] b);
    logic [1:0] idx;
    if (b[3])      idx = 2'd0;
    else if (b[2]) idx = 2'd1;
    else if (b[1]) idx = 2'd2;
    else           idx = 2'd3;
    return idx;
  endfunction

endpackage

// File: rtl/zc_ctrl.sv
module zc_ctrl (
  input  logic              countTrailing,
  input  logic              wordMode,
  output zc_pkg::zcStrobe_t strobe
);
  always_comb begin
    strobe        = '0;
    strobe.revEn  = countTrailing;
    strobe.halfEn = wordMode;
  end
endmodule

// File: rtl/zc_tree.sv
module zc_tree #(
  parameter int W = 64,
  localparam int LVLS = $clog2(W) / 2
) (
  input  logic [W-1:0]      vecIn,
  output logic [2*LVLS-1:0] cnt,
  output logic              nz
);
  for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
    localparam int NN = W >> (2 * (lv + 1));
    localparam int CB = 2 * (lv + 1);
    logic [NN*CB-1:0] cntV;
    logic [NN-1:0]    nzV;
    for (genvar n = 0; n < NN; n++) begin : g_node
      logic [3:0] flags;
      logic [1:0] pick;
      if (lv == 0) begin : g_leaf
        assign flags = vecIn[4*n +: 4];
        assign pick  = zc_pkg::pe4(flags);
        assign cntV[n*CB +: CB] = pick;
      end else begin : g_inner
        localparam int PB = CB - 2;
        logic [PB-1:0] sub;
        assign flags = g_lvl[lv-1].nzV[4*n +: 4];
        assign pick  = zc_pkg::pe4(flags);
        always_comb begin
          case (pick)
            2'd0:    sub = g_lvl[lv-1].cntV[(4*n+3)*PB +: PB];
            2'd1:    sub = g_lvl[lv-1].cntV[(4*n+2)*PB +: PB];
            2'd2:    sub = g_lvl[lv-1].cntV[(4*n+1)*PB +: PB];
            default: sub = g_lvl[lv-1].cntV[(4*n)*PB +: PB];
          endcase
        end
        assign cntV[n*CB +: CB] = {pick, sub};
      end
      assign nzV[n] = |flags;
    end
  end

  assign cnt = g_lvl[LVLS-1].cntV;
  assign nz  = g_lvl[LVLS-1].nzV[0];
endmodule

// File: rtl/zc_datapath.sv
module zc_datapath #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      operand,
  input  zc_pkg::zcStrobe_t strobe,
  output logic [W-1:0]      result
);
  localparam int H     = W / 2;
  localparam int CNT_W = $clog2(W) + 1;
  localparam int TC_W  = CNT_W - 1;

  logic [W-1:0]     revOp, wideSrc, treeIn;
  logic [H-1:0]     halfSrc;
  logic [TC_W-1:0]  treeCnt;
  logic             treeNz, opZero;
  logic [CNT_W-1:0] cntSel;
  logic [W-1:0]     nextResult;

  always_comb begin
    revOp = '0;
    for (int i = 0; i < W; i++) revOp[i] = operand[W-1-i];
  end

  // the tree always works; the zero test only steers the result mux
  assign wideSrc = strobe.revEn ? revOp : operand;
  assign halfSrc = strobe.revEn ? revOp[W-1:H] : operand[H-1:0];
  assign treeIn  = strobe.halfEn ? {halfSrc, {H{1'b1}}} : wideSrc;
  assign opZero  = strobe.halfEn ? ~|operand[H-1:0] : ~|operand;

  zc_tree #(.W(W)) u_tree (.vecIn(treeIn), .cnt(treeCnt), .nz(treeNz));

  always_comb begin
    if (opZero) cntSel = strobe.halfEn ? CNT_W'(H) : CNT_W'(W);
    else        cntSel = {1'b0, treeCnt};
    nextResult = {{(W-CNT_W){1'b0}}, cntSel};
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= nextResult;
    end
    // R5 zero operand in full-width mode reads as W one cycle later
    a_r5_zero_full: assert property (@(posedge clk) disable iff (!rst_n)
      (operand == '0 && !strobe.halfEn) |=> result == W);
    // R3 R4 word mode never exceeds half width
    a_r3_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.halfEn |=> result <= H);
  end else begin : g_comb
    assign result = nextResult;
  end

  // R1 the bit the tree points at is set
  a_r1_first_one: assert property (@(posedge clk) disable iff (!rst_n)
    treeNz |-> treeIn[W-1-int'(treeCnt)]);
  // R1 R2 nothing set above the bit the tree points at
  a_r2_above_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (treeNz && treeCnt != 0) |-> (treeIn >> (W - int'(treeCnt))) == '0);
  // R6 upper result bits stay clear
  a_r6_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    result[W-1:CNT_W] == '0);
endmodule

// File: rtl/zcount_unit.sv
module zcount_unit #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] operand,
  input  logic         countTrailing,
  input  logic         wordMode,
  output logic [W-1:0] result
);
  zc_pkg::zcStrobe_t strobe;

  zc_ctrl u_ctrl (
    .countTrailing(countTrailing),
    .wordMode(wordMode),
    .strobe(strobe)
  );

  zc_datapath #(.W(W), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .operand(operand),
    .strobe(strobe),
    .result(result)
  );
endmodule

// File: tb/sim_zcount_unit.sv
module sim_zcount_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] operand = '0;
  logic        countTrailing = 1'b0;
  logic        wordMode = 1'b0;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcount_unit u0 (
    .clk(clk), .rst_n(rst_n), .operand(operand),
    .countTrailing(countTrailing), .wordMode(wordMode), .result(result)
  );

  function automatic int refCount(logic [63:0] v, bit trail, bit word);
    int n = word ? 32 : 64;
    int c = 0;
    for (int i = 0; i < n; i++) begin
      int idx = trail ? i : n - 1 - i;
      if (v[idx]) break;
      c++;
    end
    return c;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic runOne(string req, logic [63:0] v, bit trail, bit word);
    @(negedge clk);
    operand = v; countTrailing = trail; wordMode = word;
    @(negedge clk);
    check(req, result, 64'(refCount(v, trail, word)));
    check("R6", {result[63:7], 7'd0}, 64'd0);
  endtask

  task automatic testReset();
    check("R7 reset", result, 64'd0);
  endtask

  task automatic testWalk(string req, bit trail);
    for (int i = 0; i < 64; i++) runOne(req, 64'd1 << i, trail, 1'b0);
    for (int i = 0; i < 64; i++) runOne(req, ~64'd0 << i, trail, 1'b0);
  endtask

  task automatic testMixed(string req, bit trail, bit word);
    logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 200; i++) begin
      s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
      runOne(req, s >> (i % 61), trail, word);
    end
  endtask

  task automatic testWord(string req, bit trail);
    for (int i = 0; i < 32; i++)
      runOne(req, {32'hA5C3_F00F ^ 32'(i), 32'd1 << i}, trail, 1'b1);
  endtask

  task automatic testZero();
    runOne("R5 zero full lead", 64'd0, 1'b0, 1'b0);
    check("R5 value", result, 64'd64);
    runOne("R5 zero full trail", 64'd0, 1'b1, 1'b0);
    check("R5 value", result, 64'd64);
    runOne("R5 zero word lead", 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1);
    check("R5 value", result, 64'd32);
    runOne("R5 zero word trail", 64'h8000_0001_0000_0000, 1'b1, 1'b1);
    check("R5 value", result, 64'd32);
  endtask

  task automatic testHold();
    runOne("R7 setup", 64'h0000_0100_0000_0000, 1'b0, 1'b0);
    @(negedge clk);
    operand = 64'h1; countTrailing = 1'b0; wordMode = 1'b0;
    #1;
    check("R7 hold before edge", result, 64'd23);
    @(negedge clk);
    check("R7 after edge", result, 64'd63);
  endtask

  initial begin
    #(CLK_PERIOD*2 + 2);
    testReset();
    rst_n = 1'b1;
    testWalk("R1", 1'b0);
    testWalk("R2", 1'b1);
    testMixed("R1", 1'b0, 1'b0);
    testMixed("R2", 1'b1, 1'b0);
    testWord("R3", 1'b0);
    testWord("R4", 1'b1);
    testMixed("R3", 1'b0, 1'b1);
    testMixed("R4", 1'b1, 1'b1);
    testZero();
    testHold();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule